// File: doc/BRIEF.md
# Multi-Instance Pipelined Trie Lookup Engine

This block finds the longest matching prefix for IPv4 destination addresses on behalf of several virtual router instances. All instances share one binary trie. Each trie level sits in its own pipeline stage with a private node store. A node that carries a prefix points into a per-stage table of next-hop arrays, and the request's instance number selects one entry of that array. Prefixes stay on internal nodes (the trie is not leaf-pushed). Each request therefore carries its best match so far down the pipeline, and deeper levels may replace it.

A new lookup can enter on every clock, and a full pipeline delivers one result per clock. A route change enters as a single write bubble in place of one lookup. The bubble carries an optional node write for every stage and one next-hop array write aimed at a chosen stage. Each stage applies its part when the bubble passes through it. Lookups that entered ahead of the bubble therefore see the old trie, and lookups that entered behind it see the new one.

Top module: `mtrie_lpm_engine`

## Requirements
- R1: After reset every node store and array entry reads as zero, so the trie is empty and every lookup from every instance misses.
- R2: A lookup accepted at one rising edge produces its result exactly LEVELS rising edges later. Back-to-back lookups give back-to-back results in the order they were issued.
- R3: The result is the next hop of the deepest node on the address path whose array entry for the request's instance is valid. A shallower match is kept when the deeper nodes have no valid entry for that instance.
- R4: An array entry written for one instance never affects lookups issued with another instance number.
- R5: Descent ends when the child chosen by the address bit is absent. The result then carries the best match found above that point, and a node at level 0 with a prefix acts as the instance's default route.
- R6: A write bubble produces no result. When `upd_valid` and `req_valid` are both high in the same cycle, the bubble is taken and that lookup is dropped.
- R7: Lookups issued before a bubble see the trie as it was before the update. Lookups issued on the cycle right after the bubble see the updated trie.
- R8: Level i tests address bit 31-i, where 0 selects the left child and 1 the right child. The root is entry 0 of level 0. A node word holds these fields from MSB to LSB: left-valid (1), right-valid (1), prefix-present (1), left pointer (5), right pointer (5), array index (4).
- R9: The array write of a bubble sets entry (stage, index, instance) to the given valid bit and next hop. Writing valid=0 removes the route, and writing valid=1 to an existing entry replaces its next hop.
- R10: On a miss, `res_hit` is 0, `res_default` is 1 and `res_nh` equals the DFLT_NH parameter (default 8'hFF). On a hit, `res_default` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | IPv4 destination address |
| req_vr | input | 2 | Virtual router instance of the request |
| upd_valid | input | 1 | Write bubble strobe (takes the lookup slot) |
| upd_node_we | input | 8 | Per-stage node write enable (bit i for level i) |
| upd_node_addr | input | 40 | Per-stage node address, 5 bits per level, level 0 at LSB |
| upd_node_data | input | 136 | Per-stage node word, 17 bits per level, level 0 at LSB |
| upd_arr_en | input | 1 | Bubble carries a next-hop array write |
| upd_arr_stage | input | 4 | Level whose array table is written |
| upd_arr_idx | input | 4 | Array index within that level |
| upd_arr_vr | input | 2 | Instance entry within the array |
| upd_arr_valid | input | 1 | New valid bit of the entry |
| upd_arr_nh | input | 8 | New next-hop pointer of the entry |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | A prefix matched for the instance |
| res_default | output | 1 | No prefix matched; default result given |
| res_nh | output | 8 | Next-hop pointer (DFLT_NH on a miss) |

## Verification
The hardest situation to reach is a lookup that runs through the same stages in the cycles right before and right after a write bubble, where old and new trie contents must never mix. The stimulus issues a lookup, a bubble that adds a longer prefix and the same lookup again on three consecutive cycles, and the scoreboard expects the old answer for the first lookup and the new one for the second. The trie also holds nodes with prefixes that are valid for only one instance, placed on the paths of other instances. Lookups from those other instances must skip such nodes and keep their shallower matches. Bubbles and lookups are also mixed at random over back-to-back traffic.

// File: rtl/trie_pkg.sv
package trie_pkg;
  localparam int ADDR_W     = 32;
  localparam int VR_W       = 2;
  localparam int NUM_VR     = 1 << VR_W;
  localparam int NODE_AW    = 5;
  localparam int NODE_DEPTH = 1 << NODE_AW;
  localparam int NHA_AW     = 4;
  localparam int NHA_DEPTH  = 1 << NHA_AW;
  localparam int NH_W       = 8;
  localparam int LVL_W      = 4;

  // Trie node word, MSB first.
  typedef struct packed {
    logic               lc_v;
    logic               rc_v;
    logic               pfx_v;
    logic [NODE_AW-1:0] lc;
    logic [NODE_AW-1:0] rc;
    logic [NHA_AW-1:0]  nha;
  } node_t;

  localparam int NODE_W = $bits(node_t);

  // One instance entry inside a next-hop array.
  typedef struct packed {
    logic            v;
    logic [NH_W-1:0] nh;
  } nhe_t;

  // Token travelling through the pipeline: a lookup or a write bubble.
  typedef struct packed {
    logic               lk_v;
    logic               bub_v;
    logic [ADDR_W-1:0]  addr;
    logic [VR_W-1:0]    vr;
    logic               alive;
    logic [NODE_AW-1:0] ptr;
    logic               hit;
    logic [NH_W-1:0]    nh;
    logic               aw_en;
    logic [LVL_W-1:0]   aw_stage;
    logic [NHA_AW-1:0]  aw_idx;
    logic [VR_W-1:0]    aw_vr;
    nhe_t               aw_data;
  } tok_t;
endpackage

// File: rtl/trie_level_mem.sv
module trie_level_mem
  import trie_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               node_we,
  input  logic [NODE_AW-1:0] node_waddr,
  input  node_t              node_wdata,
  input  logic [NODE_AW-1:0] node_raddr,
  output node_t              node_rdata,
  input  logic               arr_we,
  input  logic [NHA_AW-1:0]  arr_widx,
  input  logic [VR_W-1:0]    arr_wvr,
  input  nhe_t               arr_wdata,
  input  logic [NHA_AW-1:0]  arr_ridx,
  input  logic [VR_W-1:0]    arr_rvr,
  output nhe_t               arr_rdata
);
  node_t node_q [NODE_DEPTH];
  nhe_t  arr_q  [NHA_DEPTH][NUM_VR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NODE_DEPTH; i++) node_q[i] <= '0;
    end else if (node_we) begin
      node_q[node_waddr] <= node_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NHA_DEPTH; i++)
        for (int j = 0; j < NUM_VR; j++) arr_q[i][j] <= '0;
    end else if (arr_we) begin
      arr_q[arr_widx][arr_wvr] <= arr_wdata;
    end
  end

  assign node_rdata = node_q[node_raddr];
  assign arr_rdata  = arr_q[arr_ridx][arr_rvr];
endmodule

// File: rtl/trie_stage.sv
module trie_stage
  import trie_pkg::*;
#(
  parameter int LEVELS = 8,
  parameter int IDX    = 0,
  parameter int WRW    = LEVELS * (1 + NODE_AW + NODE_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  tok_t           tok_i,
  input  logic [WRW-1:0] wrv_i,
  output tok_t           tok_o,
  output logic [WRW-1:0] wrv_o
);
  localparam int AD_OFS = LEVELS;
  localparam int DT_OFS = LEVELS + LEVELS * NODE_AW;
  localparam int BIT    = ADDR_W - 1 - IDX;

  logic               n_we;
  logic [NODE_AW-1:0] n_waddr;
  node_t              n_wdata;
  logic               a_we;
  node_t              rd_node;
  nhe_t               rd_ent;
  tok_t               nxt;
  tok_t               tok_q;
  logic [WRW-1:0]     wrv_q;
  logic               adv;

  assign n_we    = tok_i.bub_v & wrv_i[IDX];
  assign n_waddr = wrv_i[AD_OFS + IDX*NODE_AW +: NODE_AW];
  assign n_wdata = node_t'(wrv_i[DT_OFS + IDX*NODE_W +: NODE_W]);
  assign a_we    = tok_i.bub_v & tok_i.aw_en & (tok_i.aw_stage == LVL_W'(IDX));

  trie_level_mem mem_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .node_we   (n_we),
    .node_waddr(n_waddr),
    .node_wdata(n_wdata),
    .node_raddr(tok_i.ptr),
    .node_rdata(rd_node),
    .arr_we    (a_we),
    .arr_widx  (tok_i.aw_idx),
    .arr_wvr   (tok_i.aw_vr),
    .arr_wdata (tok_i.aw_data),
    .arr_ridx  (rd_node.nha),
    .arr_rvr   (tok_i.vr),
    .arr_rdata (rd_ent)
  );

  // Next state: update best match, then follow the child picked by this level's bit.
  always_comb begin
    nxt = tok_i;
    if (tok_i.lk_v && tok_i.alive) begin
      if (rd_node.pfx_v && rd_ent.v) begin
        nxt.hit = 1'b1;
        nxt.nh  = rd_ent.nh;
      end
      if (tok_i.addr[BIT]) begin
        if (rd_node.rc_v) nxt.ptr = rd_node.rc;
        else              nxt.alive = 1'b0;
      end else begin
        if (rd_node.lc_v) nxt.ptr = rd_node.lc;
        else              nxt.alive = 1'b0;
      end
    end
  end

  assign adv = tok_i.lk_v | tok_i.bub_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok_q <= '0;
    end else if (adv) begin
      tok_q <= nxt;
    end else begin
      tok_q.lk_v  <= 1'b0;
      tok_q.bub_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wrv_q <= '0;
    else if (tok_i.bub_v) wrv_q <= wrv_i;
  end

  assign tok_o = tok_q;
  assign wrv_o = wrv_q;

  assert_slot_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tok_q.lk_v && tok_q.bub_v));

  assert_match_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_i.lk_v && tok_i.hit) |=> tok_q.hit);

  assert_dead_path_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_i.lk_v && !tok_i.alive) |=> (!tok_q.alive && tok_q.nh == $past(tok_i.nh)));

  assert_lookup_advances_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_i.lk_v |=> tok_q.lk_v);
endmodule

// File: rtl/mtrie_lpm_engine.sv
module mtrie_lpm_engine
  import trie_pkg::*;
#(
  parameter int              LEVELS  = 8,
  parameter logic [NH_W-1:0] DFLT_NH = 8'hFF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [VR_W-1:0]           req_vr,
  input  logic                      upd_valid,
  input  logic [LEVELS-1:0]         upd_node_we,
  input  logic [LEVELS*NODE_AW-1:0] upd_node_addr,
  input  logic [LEVELS*NODE_W-1:0]  upd_node_data,
  input  logic                      upd_arr_en,
  input  logic [LVL_W-1:0]          upd_arr_stage,
  input  logic [NHA_AW-1:0]         upd_arr_idx,
  input  logic [VR_W-1:0]           upd_arr_vr,
  input  logic                      upd_arr_valid,
  input  logic [NH_W-1:0]           upd_arr_nh,
  output logic                      res_valid,
  output logic                      res_hit,
  output logic                      res_default,
  output logic [NH_W-1:0]           res_nh
);
  localparam int WRW = LEVELS * (1 + NODE_AW + NODE_W);

  tok_t           tok0;
  logic [WRW-1:0] wrv0;
  tok_t           tok_s [LEVELS];
  logic [WRW-1:0] wrv_s [LEVELS];
  tok_t           last;

  // Slot entry: a bubble wins the slot over a lookup.
  always_comb begin
    tok0              = '0;
    tok0.lk_v         = req_valid & ~upd_valid;
    tok0.bub_v        = upd_valid;
    tok0.addr         = req_addr;
    tok0.vr           = req_vr;
    tok0.alive        = 1'b1;
    tok0.aw_en        = upd_arr_en;
    tok0.aw_stage     = upd_arr_stage;
    tok0.aw_idx       = upd_arr_idx;
    tok0.aw_vr        = upd_arr_vr;
    tok0.aw_data.v    = upd_arr_valid;
    tok0.aw_data.nh   = upd_arr_nh;
  end

  assign wrv0 = {upd_node_data, upd_node_addr, upd_node_we};

  for (genvar g = 0; g < LEVELS; g++) begin : g_stage
    if (g == 0) begin : g_first
      trie_stage #(.LEVELS(LEVELS), .IDX(g), .WRW(WRW)) stage_i (
        .clk(clk), .rst_n(rst_n), .tok_i(tok0), .wrv_i(wrv0),
        .tok_o(tok_s[g]), .wrv_o(wrv_s[g]));
    end else begin : g_next
      trie_stage #(.LEVELS(LEVELS), .IDX(g), .WRW(WRW)) stage_i (
        .clk(clk), .rst_n(rst_n), .tok_i(tok_s[g-1]), .wrv_i(wrv_s[g-1]),
        .tok_o(tok_s[g]), .wrv_o(wrv_s[g]));
    end
  end

  assign last        = tok_s[LEVELS-1];
  assign res_valid   = last.lk_v;
  assign res_hit     = last.lk_v & last.hit;
  assign res_default = last.lk_v & ~last.hit;
  assign res_nh      = last.hit ? last.nh : DFLT_NH;

  assert_bubble_takes_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |=> !tok_s[0].lk_v);
endmodule

// File: tb/mtrie_lpm_engine_tb.sv
module mtrie_lpm_engine_tb_top;
  import trie_pkg::*;

  localparam int              LEVELS = 8;
  localparam logic [NH_W-1:0] DFLT   = 8'hFF;
  localparam int              KEYS   = 1 << (LEVELS - 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                      rst_n;
  logic                      req_valid;
  logic [ADDR_W-1:0]         req_addr;
  logic [VR_W-1:0]           req_vr;
  logic                      upd_valid;
  logic [LEVELS-1:0]         upd_node_we;
  logic [LEVELS*NODE_AW-1:0] upd_node_addr;
  logic [LEVELS*NODE_W-1:0]  upd_node_data;
  logic                      upd_arr_en;
  logic [LVL_W-1:0]          upd_arr_stage;
  logic [NHA_AW-1:0]         upd_arr_idx;
  logic [VR_W-1:0]           upd_arr_vr;
  logic                      upd_arr_valid;
  logic [NH_W-1:0]           upd_arr_nh;
  logic                      res_valid, res_hit, res_default;
  logic [NH_W-1:0]           res_nh;

  mtrie_lpm_engine #(.LEVELS(LEVELS), .DFLT_NH(DFLT)) dut_i (.*);

  // Stimulus-side shadow of the trie, and the reference route tables.
  node_t           sh [LEVELS][NODE_DEPTH];
  int              n_alloc [LEVELS];
  int              h_alloc [LEVELS];
  logic            m_v  [NUM_VR][LEVELS][KEYS];
  logic [NH_W-1:0] m_nh [NUM_VR][LEVELS][KEYS];
  logic [LEVELS-1:0]  b_we;
  logic [NODE_AW-1:0] b_ad [LEVELS];
  node_t              b_dt [LEVELS];

  bit              q_hit [$];
  logic [NH_W-1:0] q_nh  [$];
  int              q_cyc [$];
  string           q_tag [$];

  int n_chk = 0, n_bad = 0, n_res = 0, n_push = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  function automatic void model_lookup(input logic [31:0] a, input int vr,
                                       output bit hit, output logic [NH_W-1:0] nh);
    hit = 0;
    nh  = DFLT;
    for (int l = LEVELS - 1; l >= 0; l--) begin
      int k;
      k = (l == 0) ? 0 : int'(a >> (32 - l));
      if (!hit && m_v[vr][l][k]) begin
        hit = 1;
        nh  = m_nh[vr][l][k];
      end
    end
  endfunction

  task automatic lookup(logic [31:0] a, int vr, string tag);
    bit h;
    logic [NH_W-1:0] nh;
    @(negedge clk);
    model_lookup(a, vr, h, nh);
    req_valid = 1'b1;
    upd_valid = 1'b0;
    req_addr  = a;
    req_vr    = VR_W'(vr);
    q_hit.push_back(h);
    q_nh.push_back(nh);
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
    n_push++;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      upd_valid = 1'b0;
    end
  endtask

  task automatic drive_bubble(bit with_req, bit aen, int st, int idx, int vr, bit v,
                              logic [NH_W-1:0] nh);
    @(negedge clk);
    req_valid = with_req;
    req_addr  = 32'hAC00_0000;
    req_vr    = '0;
    upd_valid = 1'b1;
    for (int l = 0; l < LEVELS; l++) begin
      upd_node_we[l]                       = b_we[l];
      upd_node_addr[l*NODE_AW +: NODE_AW]  = b_ad[l];
      upd_node_data[l*NODE_W +: NODE_W]    = b_dt[l];
    end
    upd_arr_en    = aen;
    upd_arr_stage = LVL_W'(st);
    upd_arr_idx   = NHA_AW'(idx);
    upd_arr_vr    = VR_W'(vr);
    upd_arr_valid = v;
    upd_arr_nh    = nh;
  endtask

  // One bubble per route: new path nodes, parent child links, prefix flag, array entry.
  task automatic add_route(int vr, logic [31:0] pfx, int len, logic [NH_W-1:0] nh);
    logic [31:0] a;
    int ptr;
    node_t n;
    a   = (len == 0) ? 32'h0 : (pfx << (32 - len));
    ptr = 0;
    b_we = '0;
    for (int l = 0; l < len; l++) begin
      bit b;
      b = a[31 - l];
      n = sh[l][ptr];
      if (b ? n.rc_v : n.lc_v) begin
        ptr = b ? int'(n.rc) : int'(n.lc);
      end else begin
        int nw;
        nw = n_alloc[l + 1];
        n_alloc[l + 1]++;
        if (b) begin n.rc_v = 1'b1; n.rc = NODE_AW'(nw); end
        else   begin n.lc_v = 1'b1; n.lc = NODE_AW'(nw); end
        sh[l][ptr] = n;
        b_we[l] = 1'b1;
        b_ad[l] = NODE_AW'(ptr);
        b_dt[l] = n;
        ptr = nw;
      end
    end
    n = sh[len][ptr];
    if (!n.pfx_v) begin
      n.pfx_v = 1'b1;
      n.nha   = NHA_AW'(h_alloc[len]);
      h_alloc[len]++;
      sh[len][ptr] = n;
      b_we[len] = 1'b1;
      b_ad[len] = NODE_AW'(ptr);
      b_dt[len] = n;
    end
    drive_bubble(1'b0, 1'b1, len, int'(n.nha), vr, 1'b1, nh);
    m_v[vr][len][int'(pfx)]  = 1'b1;
    m_nh[vr][len][int'(pfx)] = nh;
  endtask

  task automatic del_route(int vr, logic [31:0] pfx, int len);
    logic [31:0] a;
    int ptr;
    node_t n;
    a   = (len == 0) ? 32'h0 : (pfx << (32 - len));
    ptr = 0;
    for (int l = 0; l < len; l++) begin
      n   = sh[l][ptr];
      ptr = a[31 - l] ? int'(n.rc) : int'(n.lc);
    end
    n = sh[len][ptr];
    b_we = '0;
    drive_bubble(1'b0, 1'b1, len, int'(n.nha), vr, 1'b0, '0);
    m_v[vr][len][int'(pfx)] = 1'b0;
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      n_res++;
      if (q_hit.size() == 0) begin
        chk(0, "R6", "unexpected result", 1, 0);
      end else begin
        bit eh;
        logic [NH_W-1:0] enh;
        int ic;
        string tg;
        eh  = q_hit.pop_front();
        enh = q_nh.pop_front();
        ic  = q_cyc.pop_front();
        tg  = q_tag.pop_front();
        chk(res_hit == eh, tg, "hit", res_hit, eh);
        chk(res_nh == enh, tg, "next hop", res_nh, enh);
        chk(res_default == !eh, "R10", "default flag", res_default, !eh);
        chk(cyc - ic == LEVELS, "R2", "latency", cyc - ic, LEVELS);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "R2", "watchdog expired", 0, 1);
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_addr = '0; req_vr = '0; upd_valid = 0;
    upd_node_we = '0; upd_node_addr = '0; upd_node_data = '0;
    upd_arr_en = 0; upd_arr_stage = '0; upd_arr_idx = '0; upd_arr_vr = '0;
    upd_arr_valid = 0; upd_arr_nh = '0;
    for (int l = 0; l < LEVELS; l++) begin
      n_alloc[l] = (l == 0) ? 1 : 0;
      h_alloc[l] = 0;
      b_ad[l] = '0;
      b_dt[l] = '0;
      for (int i = 0; i < NODE_DEPTH; i++) sh[l][i] = '0;
      for (int v = 0; v < NUM_VR; v++)
        for (int k = 0; k < KEYS; k++) begin
          m_v[v][l][k]  = 1'b0;
          m_nh[v][l][k] = '0;
        end
    end
    b_we = '0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1", "result strobe in reset", res_valid, 0);
    rst_n = 1'b1;

    // R1: empty trie misses for every instance.
    for (int v = 0; v < NUM_VR; v++) lookup(32'hAC00_0000 ^ (v << 28), v, "R1");
    lookup(32'h0000_0000, 0, "R1");

    // Build a small shared trie.
    add_route(0, 32'h0,        0, 8'h10);
    add_route(0, 32'b1010,     4, 8'h11);
    add_route(0, 32'b101011,   6, 8'h12);
    add_route(1, 32'b1,        1, 8'h20);
    add_route(1, 32'b1010,     4, 8'h21);
    add_route(3, 32'b1010101,  7, 8'h30);

    // R3: deepest valid match wins; shallower kept when deeper entry invalid.
    lookup(32'hAC00_0000, 0, "R3");
    lookup(32'hAC00_0000, 1, "R3");
    lookup(32'hAA00_0000, 0, "R3");
    lookup(32'hAA00_0000, 3, "R3");
    // R4: instance isolation.
    lookup(32'hAC00_0000, 2, "R4");
    lookup(32'hAC00_0000, 3, "R4");
    lookup(32'hAA00_0000, 2, "R4");
    // R5: descent ends at a missing child, best match carried on.
    lookup(32'hA000_0000, 0, "R5");
    lookup(32'h5000_0000, 0, "R5");
    lookup(32'h5000_0000, 1, "R5");
    // R8: bit sense at the root.
    lookup(32'h8000_0000, 1, "R8");
    lookup(32'h7FFF_FFFF, 1, "R8");

    // R7: old trie before the bubble, new trie right after it.
    lookup(32'hB000_0000, 2, "R7");
    add_route(2, 32'b1011, 4, 8'h40);
    lookup(32'hB000_0000, 2, "R7");

    // R9: removal and replacement of an entry.
    del_route(0, 32'b101011, 6);
    lookup(32'hAC00_0000, 0, "R9");
    add_route(1, 32'b1010, 4, 8'h22);
    lookup(32'hAC00_0000, 1, "R9");
    idle(LEVELS + 2);

    // R6: lookup colliding with a bubble is dropped.
    b_we = '0;
    drive_bubble(1'b1, 1'b0, 0, 0, 0, 1'b0, '0);
    lookup(32'hAA00_0000, 3, "R6");
    idle(LEVELS + 2);
    chk(n_res == n_push, "R6", "results vs lookups", n_res, n_push);

    // R2/R3: back-to-back random traffic with interleaved route adds.
    for (int i = 0; i < 240; i++) begin
      if (i % 40 == 0) begin
        int ln;
        ln = 1 + int'($urandom_range(0, LEVELS - 2));
        add_route(int'($urandom_range(0, NUM_VR - 1)),
                  32'($urandom_range(0, (1 << ln) - 1)), ln,
                  NH_W'($urandom_range(0, 254)));
      end else begin
        lookup({8'(8'hA0 | 8'($urandom_range(0, 31)) ^ 8'($urandom_range(0, 1) << 7)),
                24'($urandom)}, int'($urandom_range(0, NUM_VR - 1)), "R3");
      end
    end
    idle(LEVELS + 4);
    chk(q_hit.size() == 0, "R2", "pending results", q_hit.size(), 0);
    report();
    $finish;
  end
endmodule